// File: doc/BRIEF.md
# Frequency Lock Detector with Alternating Windows

This block decides whether a PLL feedback clock runs at the same frequency as its reference clock, and reports the result as two flags. A counter in the reference domain measures a window of reference cycles. Feedback edges reach the reference domain through a toggle synchronizer, and a second counter counts them over the same window. At the end of each window the feedback count is compared with the window length.

Window lengths alternate between a short window of `N_SHORT` cycles and a long window of `N_SHORT + K_EXTRA` cycles. Because the two lengths differ, a feedback clock that aliases onto the reference is unlikely to pass both windows. Lock is declared only when a passing short window is followed by a passing long window. While the block is acquiring, the allowed error is `TOL_TIGHT` counts. Once locked, the allowed error doubles, so small phase jitter does not make the flag chatter.

The sticky flag records whether the most recent loss of lock was expected. A divider change counts as expected. Stop mode preserves the flag's earlier value across the stop.

Top module: `pll_lock_detect`

## Requirements
- R1: During reset and right after it, `lock` and `lock_sticky` are both 0.
- R2: `lock` can rise only at the end of a long window (`N_SHORT+K_EXTRA` reference cycles) that directly follows a passing short window (`N_SHORT` cycles). So `lock` stays 0 for at least `2*N_SHORT+K_EXTRA-1` reference cycles after reset.
- R3: While unlocked, a window passes only when |feedback count − window length| ≤ `TOL_TIGHT`. A feedback clock about 10 % slow does not lock, and neither does one at about twice the reference rate (which aliases in the synchronizer).
- R4: While locked, a window passes when the error is ≤ 2·`TOL_TIGHT`. A feedback clock that is off by up to that much keeps `lock` high, with no drop, for as long as it stays there.
- R5: A failing window while locked clears `lock` in the cycle after the window ends. Acquisition then restarts with a short window and the tight tolerance.
- R6: While `ext_clk_mode` is 1, `lock` is 0 from the next cycle on and the windows are held cleared. After release, the block acquires lock again.
- R7: The first lock after reset sets `lock_sticky` to 1.
- R8: A one-cycle `div_change` clears `lock` and `lock_sticky` on the next cycle. On the next relock, `lock_sticky` returns to 1.
- R9: After a loss of lock caused by a failing window, the next relock sets `lock` but leaves `lock_sticky` at 0.
- R10: While `stop_mode` is 1, `lock` is 0 from the next cycle on. After stop ends and lock returns, `lock_sticky` equals the value it had just before stop began.
- R11: `lock_sticky` is never 1 while `lock` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all status logic runs here |
| fb_clk | input | 1 | Divided PLL feedback clock, at most the reference rate |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of both clocks |
| ext_clk_mode | input | 1 | 1 = PLL bypassed; lock is forced off |
| div_change | input | 1 | One-cycle strobe: the multiplier divider was reprogrammed |
| stop_mode | input | 1 | 1 = low-power stop with the PLL off |
| lock | output | 1 | Frequency lock status |
| lock_sticky | output | 1 | Set on lock unless the last loss was unexpected |

## Verification
The hardest state to reach is the locked state with a feedback clock that fails the tight tolerance but passes the relaxed one. Such a clock cannot reliably acquire lock on its own. The bench therefore first locks at exactly the reference rate. It then retimes the feedback to 4 % slow while the block stays locked, and watches every cycle for a drop. To cover the sticky-flag history, the bench chains losses from a frequency step, a divider strobe and two stop periods, each begun from a different flag value.

// File: rtl/lockdet_pkg.sv
// Shared types for the lock detector.
package lockdet_pkg;
    // Which window length is being measured.
    typedef enum logic {WIN_SHORT = 1'b0, WIN_LONG = 1'b1} win_e;
endpackage

// File: rtl/fb_edge_sync.sv
// Brings feedback edges into the reference domain.
// A flop in the feedback domain toggles on each feedback edge. A three-flop
// chain in the reference domain resynchronizes it and turns each change
// into a one-cycle pulse.
// Assumes: the feedback rate is at most the reference rate, and rst_n is
// seen by several feedback edges.
module fb_edge_sync (
    input  logic fb_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic fb_pulse
);
    logic fb_tog;
    logic [2:0] sync_q;

    // Toggle once per feedback rising edge.
    always_ff @(posedge fb_clk) begin
        if (!rst_n) fb_tog <= 1'b0;
        else        fb_tog <= ~fb_tog;
    end

    // Resynchronize the toggle into the reference domain.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], fb_tog};
    end

    assign fb_pulse = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/win_timer.sv
// Generates alternating short and long measurement windows on the
// reference clock, and counts feedback pulses inside each one.
// fb_total is the count including the pulse in the final cycle; it is
// valid when win_end is high.
// Assumes: at most one feedback pulse per reference cycle.
module win_timer
    import lockdet_pkg::*;
#(
    parameter int N_SHORT = 32,
    parameter int K_EXTRA = 8,
    parameter int CW      = $clog2(N_SHORT + K_EXTRA + 1) + 1
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          fb_pulse,
    output logic          win_end,
    output win_e          win_kind,
    output logic [CW-1:0] win_len,
    output logic [CW-1:0] fb_total
);
    localparam logic [CW-1:0] LEN_S = CW'(N_SHORT);
    localparam logic [CW-1:0] LEN_L = CW'(N_SHORT + K_EXTRA);

    logic [CW-1:0] ref_cnt;
    logic [CW-1:0] fb_cnt;

    assign win_len  = (win_kind == WIN_LONG) ? LEN_L : LEN_S;
    assign win_end  = (ref_cnt == win_len - CW'(1));
    assign fb_total = fb_cnt + CW'(fb_pulse);

    // Advance the window; clear both counts at each window start.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || restart) begin
            ref_cnt  <= '0;
            fb_cnt   <= '0;
            win_kind <= WIN_SHORT;
        end else if (win_end) begin
            ref_cnt  <= '0;
            fb_cnt   <= '0;
            win_kind <= (win_kind == WIN_LONG) ? WIN_SHORT : WIN_LONG;
        end else begin
            ref_cnt <= ref_cnt + CW'(1);
            fb_cnt  <= fb_total;
        end
    end
endmodule

// File: rtl/lock_eval.sv
// Judges each finished window and keeps the lock and sticky flags.
// The tolerance is tight while unlocked and doubled while locked.
// Divider change, stop mode and bypass mode all hold the windows cleared.
// Assumes: the window signals come from win_timer in the same domain.
module lock_eval
    import lockdet_pkg::*;
#(
    parameter int TOL_TIGHT = 1,
    parameter int CW        = 8
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          win_end,
    input  win_e          win_kind,
    input  logic [CW-1:0] win_len,
    input  logic [CW-1:0] fb_total,
    input  logic          ext_clk_mode,
    input  logic          div_change,
    input  logic          stop_mode,
    output logic          restart,
    output logic          lock,
    output logic          lock_sticky
);
    localparam logic [CW-1:0] TOL_T = CW'(TOL_TIGHT);
    localparam logic [CW-1:0] TOL_R = CW'(2 * TOL_TIGHT);

    logic [CW-1:0] err;
    logic          pass;
    logic          hold;
    logic          relock_val;
    logic          stop_q;

    // Size of the frequency error and the pass decision.
    always_comb begin
        err  = (fb_total > win_len) ? (fb_total - win_len) : (win_len - fb_total);
        pass = (err <= (lock ? TOL_R : TOL_T));
    end

    assign hold    = ext_clk_mode | stop_mode | div_change;
    assign restart = hold | (win_end & ~pass);

    // Update the lock flags and the sticky value to apply on relock.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            lock        <= 1'b0;
            lock_sticky <= 1'b0;
            relock_val  <= 1'b1;
            stop_q      <= 1'b0;
        end else begin
            stop_q <= stop_mode;
            if (div_change) begin
                lock        <= 1'b0;
                lock_sticky <= 1'b0;
                relock_val  <= 1'b1;
            end else if (stop_mode) begin
                if (!stop_q && lock) relock_val <= lock_sticky;
                lock        <= 1'b0;
                lock_sticky <= 1'b0;
            end else if (ext_clk_mode) begin
                lock        <= 1'b0;
                lock_sticky <= 1'b0;
            end else if (win_end) begin
                if (!pass) begin
                    if (lock) relock_val <= 1'b0;
                    lock        <= 1'b0;
                    lock_sticky <= 1'b0;
                end else if (win_kind == WIN_LONG && !lock) begin
                    lock        <= 1'b1;
                    lock_sticky <= relock_val;
                end
            end
        end
    end
endmodule

// File: rtl/pll_lock_detect.sv
// Top of the frequency lock detector: the synchronizer, the window timer
// and the evaluator, all reporting in the reference clock domain.
// Assumes: fb_clk is the divided feedback and runs no faster than ref_clk.
module pll_lock_detect
    import lockdet_pkg::*;
#(
    parameter int N_SHORT   = 32,
    parameter int K_EXTRA   = 8,
    parameter int TOL_TIGHT = 1
) (
    input  logic ref_clk,
    input  logic fb_clk,
    input  logic rst_n,
    input  logic ext_clk_mode,
    input  logic div_change,
    input  logic stop_mode,
    output logic lock,
    output logic lock_sticky
);
    localparam int CW = $clog2(N_SHORT + K_EXTRA + 1) + 1;

    logic          fb_pulse;
    logic          restart;
    logic          win_end;
    win_e          win_kind;
    logic          win_long;
    logic [CW-1:0] win_len;
    logic [CW-1:0] fb_total;

    assign win_long = (win_kind == WIN_LONG);

    fb_edge_sync u_sync (
        .fb_clk  (fb_clk),
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .fb_pulse(fb_pulse)
    );

    win_timer #(.N_SHORT(N_SHORT), .K_EXTRA(K_EXTRA), .CW(CW)) u_win (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .restart (restart),
        .fb_pulse(fb_pulse),
        .win_end (win_end),
        .win_kind(win_kind),
        .win_len (win_len),
        .fb_total(fb_total)
    );

    lock_eval #(.TOL_TIGHT(TOL_TIGHT), .CW(CW)) u_eval (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .win_end     (win_end),
        .win_kind    (win_kind),
        .win_len     (win_len),
        .fb_total    (fb_total),
        .ext_clk_mode(ext_clk_mode),
        .div_change  (div_change),
        .stop_mode   (stop_mode),
        .restart     (restart),
        .lock        (lock),
        .lock_sticky (lock_sticky)
    );
endmodule

// File: rtl/pll_lock_detect_chk.sv
// Property checker bound to the lock detector top.
module pll_lock_detect_chk #(
    parameter int N_SHORT = 32,
    parameter int K_EXTRA = 8
) (
    input logic ref_clk,
    input logic rst_n,
    input logic ext_clk_mode,
    input logic div_change,
    input logic stop_mode,
    input logic win_end,
    input logic win_long,
    input logic lock,
    input logic lock_sticky
);
    localparam int MIN_LOCK = 2 * N_SHORT + K_EXTRA - 1;

    // Cycles since reset, saturating; used in place of a long delay.
    logic [15:0] since_rst;
    always_ff @(posedge ref_clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (~&since_rst)       since_rst <= since_rst + 16'd1;
    end

    a_r1_reset_clear: assert property (@(posedge ref_clk)
        !rst_n |=> (!lock && !lock_sticky));
    a_r2_rise_after_long: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock) |-> $past(win_end && win_long));
    a_r2_min_time: assert property (@(posedge ref_clk) disable iff (!rst_n)
        lock |-> (since_rst >= 16'(MIN_LOCK)));
    a_r6_bypass_no_lock: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ext_clk_mode |=> !lock);
    a_r8_div_clears: assert property (@(posedge ref_clk) disable iff (!rst_n)
        div_change |=> (!lock && !lock_sticky));
    a_r10_stop_no_lock: assert property (@(posedge ref_clk) disable iff (!rst_n)
        stop_mode |=> !lock);
    a_r11_sticky_needs_lock: assert property (@(posedge ref_clk) disable iff (!rst_n)
        lock_sticky |-> lock);
endmodule

bind pll_lock_detect pll_lock_detect_chk #(.N_SHORT(N_SHORT), .K_EXTRA(K_EXTRA)) u_chk (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .ext_clk_mode(ext_clk_mode),
    .div_change  (div_change),
    .stop_mode   (stop_mode),
    .win_end     (win_end),
    .win_long    (win_long),
    .lock        (lock),
    .lock_sticky (lock_sticky)
);

// File: tb/sim_pll_lock_detect.sv
`timescale 1ns/1ps
module sim_pll_lock_detect;
    localparam int N_SHORT   = 32;
    localparam int K_EXTRA   = 8;
    localparam int TOL_TIGHT = 1;
    localparam int MIN_LOCK  = 2 * N_SHORT + K_EXTRA - 1;

    logic ref_clk = 1'b0;
    logic fb_clk  = 1'b0;
    logic rst_n   = 1'b0;
    logic ext_clk_mode = 1'b0;
    logic div_change   = 1'b0;
    logic stop_mode    = 1'b0;
    logic lock;
    logic lock_sticky;

    real fb_half = 10.0;
    int  n_checks = 0;
    int  n_errors = 0;
    int  cyc = 0;
    int  sticky_viol = 0;

    pll_lock_detect #(.N_SHORT(N_SHORT), .K_EXTRA(K_EXTRA), .TOL_TIGHT(TOL_TIGHT)) u0 (
        .ref_clk     (ref_clk),
        .fb_clk      (fb_clk),
        .rst_n       (rst_n),
        .ext_clk_mode(ext_clk_mode),
        .div_change  (div_change),
        .stop_mode   (stop_mode),
        .lock        (lock),
        .lock_sticky (lock_sticky)
    );

    always #10 ref_clk = ~ref_clk;

    initial begin
        #7;
        forever #(fb_half) fb_clk = ~fb_clk;
    end

    // Cycle count, the watchdog and the R11 monitor, sampled mid-cycle.
    always @(negedge ref_clk) begin
        cyc <= cyc + 1;
        if (rst_n && lock_sticky && !lock) sticky_viol <= sticky_viol + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual cycles=%0d expected <150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_lock(input int maxc, output int got, output int took);
        got = 0;
        took = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge ref_clk);
            took = i + 1;
            if (lock) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic wait_unlock(input int maxc, output int got);
        got = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge ref_clk);
            if (!lock) begin
                got = 1;
                break;
            end
        end
    endtask

    // Count the cycles in which lock is high over a run.
    task automatic count_high(input int n, output int highs, output int drops);
        int prev;
        highs = 0;
        drops = 0;
        prev = lock;
        for (int i = 0; i < n; i++) begin
            @(negedge ref_clk);
            if (lock) highs++;
            if (prev == 1 && lock == 0) drops++;
            prev = lock;
        end
    endtask

    initial begin
        int got, took, highs, drops, early;
        // R1: flags low while reset is held
        repeat (6) @(negedge ref_clk);
        check("R1 lock in reset", lock, 0);
        check("R1 sticky in reset", lock_sticky, 0);
        rst_n = 1'b1;

        // R2: no lock before a short and a long window have both passed
        early = 0;
        for (int i = 0; i < MIN_LOCK; i++) begin
            @(negedge ref_clk);
            if (lock) early++;
        end
        check("R2 no early lock", early, 0);
        wait_lock(400, got, took);
        check("R2 lock acquired at matching rate", got, 1);
        check("R7 sticky set on first lock", lock_sticky, 1);

        // R4: 4% slow feedback stays locked under the relaxed tolerance
        fb_half = 10.4;
        count_high(2000, highs, drops);
        check("R4 no lock drop with small error", drops, 0);
        check("R4 lock held every cycle", highs, 2000);

        // R5: a 10% slow feedback loses lock within a few windows
        fb_half = 11.0;
        wait_unlock(300, got);
        check("R5 lock lost on large error", got, 1);
        check("R9 sticky cleared on unexpected loss", lock_sticky, 0);

        // R3: tight tolerance rejects 10% slow feedback
        count_high(1000, highs, drops);
        check("R3 no lock at 10% slow", highs, 0);

        // R3: feedback at twice the reference rate aliases and must not lock
        fb_half = 5.05;
        count_high(1000, highs, drops);
        check("R3 no lock on aliased feedback", highs, 0);

        // R9: relock after unexpected loss leaves sticky clear
        fb_half = 10.0;
        wait_lock(600, got, took);
        check("R9 relock after unexpected loss", got, 1);
        check("R9 sticky stays clear", lock_sticky, 0);

        // R8: divider change clears both flags next cycle; relock sets sticky
        div_change = 1'b1;
        @(negedge ref_clk);
        div_change = 1'b0;
        check("R8 lock cleared by divider change", lock, 0);
        check("R8 sticky cleared by divider change", lock_sticky, 0);
        wait_lock(600, got, took);
        check("R8 relock after divider change", got, 1);
        check("R8 sticky set after divider relock", lock_sticky, 1);

        // R10: stop mode with sticky=1 restores sticky=1
        stop_mode = 1'b1;
        count_high(100, highs, drops);
        check("R10 no lock during stop", highs, 0);
        stop_mode = 1'b0;
        wait_lock(600, got, took);
        check("R10 relock after stop", got, 1);
        check("R10 sticky restored to 1", lock_sticky, 1);

        // R10: stop mode entered with sticky=0 keeps it 0
        fb_half = 11.0;
        wait_unlock(300, got);
        fb_half = 10.0;
        wait_lock(600, got, took);
        check("R9 relock with sticky clear", lock_sticky, 0);
        stop_mode = 1'b1;
        repeat (50) @(negedge ref_clk);
        stop_mode = 1'b0;
        wait_lock(600, got, took);
        check("R10 relock after second stop", got, 1);
        check("R10 sticky restored to 0", lock_sticky, 0);

        // R6: bypass mode holds lock low, then lock returns on release
        ext_clk_mode = 1'b1;
        @(negedge ref_clk);
        check("R6 lock low one cycle into bypass", lock, 0);
        count_high(500, highs, drops);
        check("R6 no lock in bypass", highs, 0);
        ext_clk_mode = 1'b0;
        wait_lock(600, got, took);
        check("R6 relock after bypass", got, 1);
        check("R6 relock not before two windows", (took >= MIN_LOCK) ? 1 : 0, 1);

        // R11: sticky never seen high with lock low
        check("R11 sticky implies lock", sticky_viol, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule